// File: doc/BRIEF.md
# Debug Entry Controller

This block decides when a processor core stops normal execution and hands control to an external debug port. Ten event sources each raise a one-cycle pulse. A pulse is recognised only when the relevant machine-state bits allow it. A recognised pulse sets a sticky bit in a cause register. Each cause bit has a matching bit in an enable register. When any enabled cause is pending and the global debug enable is high, the controller commits to entry. It then waits for the pipeline to report empty, and after that it switches instruction fetch to the debug port.

While in debug mode the block raises a freeze output so that peripherals can halt. It also drives a two-bit status code of binary 11. The debug port reads the cause register to learn why entry happened, and that read clears the register. A return command from the port ends debug mode. A machine-check event that arrives while machine-check handling is disabled sends the core to a check-stop state instead. That state lasts until reset. When debug mode is disabled, software can drive freeze directly.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: Each cause bit, indexed as in the causeEvt port, is set by a recognised one-cycle pulse and stays set until the cause register is read. causeRdata always shows the current cause register.
- R2: Instruction breakpoint (bit 6) and load/store breakpoint (bit 7) pulses are recognised only when msrRi=1 or bkptUnmask=1.
- R3: Peripheral breakpoint pulses (bit 8) are recognised only when msrRi=1, whatever the value of bkptUnmask.
- R4: External interrupt (bit 1) and decrementer (bit 2) pulses are recognised only when msrEe=1.
- R5: Development-port request (bit 9), alignment (bit 3), program (bit 4) and system call (bit 5) pulses are always recognised, including when msrRi=0.
- R6: Entry starts only when some cause bit and its enable bit (written through enWr/enWdata) are both 1 and dbgEnable=1. The entry decision is made on the edge after the cause bit is set.
- R7: After entry starts, fetchFromPort rises on the edge after the first edge at which pipeEmpty=1 is sampled. While pipeEmpty=0 the block keeps waiting.
- R8: While in debug mode, fetchFromPort=1, freeze=1 and statusCode=2'b11. Outside debug mode statusCode=2'b00.
- R9: A causeRd cycle clears every cause bit on the next edge. A pulse recognised in that same cycle still leaves its bit set.
- R10: In debug mode, dbgReturn=1 leaves debug mode on the next edge. fetchFromPort, freeze and statusCode then revert.
- R11: A machine-check pulse (bit 0) with msrMe=0, in normal or waiting state, raises checkStop on the next edge. checkStop holds until reset and the cause bit is not set. With msrMe=1 the pulse sets cause bit 0 instead.
- R12: Outside debug mode, freeze equals swFreeze when dbgEnable=0 and is 0 when dbgEnable=1.
- R13: After reset, all outputs are 0, and the cause and enable registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| causeEvt | input | 10 | One-cycle event pulses, one per cause |
| msrRi | input | 1 | Recoverable-interrupt state bit |
| msrEe | input | 1 | External-enable state bit |
| msrMe | input | 1 | Machine-check-enable state bit |
| bkptUnmask | input | 1 | Recognise code and data breakpoints regardless of msrRi |
| dbgEnable | input | 1 | Global debug-mode enable |
| swFreeze | input | 1 | Software freeze request |
| enWr | input | 1 | Write strobe for the enable register |
| enWdata | input | 10 | Enable register write data |
| causeRd | input | 1 | Read strobe for the cause register (clears it) |
| causeRdata | output | 10 | Current cause register contents |
| pipeEmpty | input | 1 | Pipeline drained indication |
| dbgReturn | input | 1 | Return command from the debug port |
| fetchFromPort | output | 1 | Instruction fetch comes from the debug port |
| freeze | output | 1 | Freeze indication to peripherals |
| statusCode | output | 2 | Visible status, 2'b11 in debug mode |
| checkStop | output | 1 | Core is in check-stop |

## Verification
A pulse sampled at one edge shows in causeRdata right after that edge. The entry decision is taken one edge later. fetchFromPort, freeze and statusCode rise one edge after pipeEmpty is first sampled high. The first possible rise is therefore the second edge after the pulse. A return command or a machine-check stop changes the outputs on the very next edge. The bench drives inputs just after a falling edge and steps a behavioural model at each rising edge. It compares every output at the following falling edge, so each result is sampled in the cycle it is due.

// File: rtl/dme_pkg.sv
package dme_pkg;
  localparam int NUM_CAUSES = 10;
  localparam int STATUS_W   = 2;

  localparam int C_MCHK  = 0;
  localparam int C_EXT   = 1;
  localparam int C_DEC   = 2;
  localparam int C_ALIGN = 3;
  localparam int C_PROG  = 4;
  localparam int C_SC    = 5;
  localparam int C_IBKPT = 6;
  localparam int C_LBKPT = 7;
  localparam int C_PBKPT = 8;
  localparam int C_NMI   = 9;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_DEBUG = 2'd2,
    ST_CHK   = 2'd3
  } dmeState_e;

  typedef struct packed {
    logic entryReq;
    logic chkStopReq;
  } dmeReq_t;

  typedef struct packed {
    logic inDebug;
    logic inChkStop;
  } dmeCtl_t;
endpackage

// File: rtl/dme_datapath.sv
module dme_datapath
  import dme_pkg::*;
#(
  parameter int NC = NUM_CAUSES,
  parameter int SW = STATUS_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NC-1:0] causeEvt,
  input  logic          msrRi,
  input  logic          msrEe,
  input  logic          msrMe,
  input  logic          bkptUnmask,
  input  logic          dbgEnable,
  input  logic          swFreeze,
  input  logic          enWr,
  input  logic [NC-1:0] enWdata,
  input  logic          causeRd,
  input  dmeCtl_t       ctl,
  output dmeReq_t       req,
  output logic [NC-1:0] causeRdata,
  output logic          fetchFromPort,
  output logic          freeze,
  output logic [SW-1:0] statusCode,
  output logic          checkStop
);
  localparam logic [SW-1:0] DEBUG_CODE = '1;

  logic [NC-1:0] causeQ, enQ, recognise, causeSet;

  for (genvar i = 0; i < NC; i++) begin : g_qual
    if (i == C_MCHK) begin : g_mchk
      assign recognise[i] = msrMe;
    end else if (i == C_EXT || i == C_DEC) begin : g_ee
      assign recognise[i] = msrEe;
    end else if (i == C_IBKPT || i == C_LBKPT) begin : g_bk
      assign recognise[i] = msrRi | bkptUnmask;
    end else if (i == C_PBKPT) begin : g_pbk
      assign recognise[i] = msrRi;
    end else begin : g_always
      assign recognise[i] = 1'b1;
    end
  end

  assign causeSet = causeEvt & recognise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ <= '0;
      enQ    <= '0;
    end else begin
      causeQ <= (causeRd ? '0 : causeQ) | causeSet;
      if (enWr) enQ <= enWdata;
    end
  end

  assign req.entryReq   = dbgEnable & (|(causeQ & enQ));
  assign req.chkStopReq = causeEvt[C_MCHK] & ~msrMe;

  assign causeRdata    = causeQ;
  assign fetchFromPort = ctl.inDebug;
  assign freeze        = ctl.inDebug | (~dbgEnable & swFreeze);
  assign statusCode    = ctl.inDebug ? DEBUG_CODE : '0;
  assign checkStop     = ctl.inChkStop;

  // R9: a recognised pulse survives a same-cycle clearing read
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (causeSet != '0) |=> ((causeQ & $past(causeSet)) == $past(causeSet)));

  // R8: debug state drives the visible outputs
  assert_debug_outputs_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.inDebug |-> (freeze && statusCode == DEBUG_CODE && fetchFromPort));

  // R11: check-stop never leaves a machine-check cause behind
  assert_mchk_no_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    (req.chkStopReq && !causeRd && !$isunknown(causeQ)) |=> (causeQ[C_MCHK] == $past(causeQ[C_MCHK])));
endmodule

// File: rtl/dme_control.sv
module dme_control
  import dme_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dmeReq_t req,
  input  logic    pipeEmpty,
  input  logic    dbgReturn,
  output dmeCtl_t ctl
);
  dmeState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN: begin
        if (req.chkStopReq)    stateNext = ST_CHK;
        else if (req.entryReq) stateNext = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (req.chkStopReq)    stateNext = ST_CHK;
        else if (pipeEmpty)    stateNext = ST_DEBUG;
      end
      ST_DEBUG: if (dbgReturn) stateNext = ST_RUN;
      ST_CHK:   stateNext = ST_CHK;
      default:  stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assign ctl.inDebug   = (state == ST_DEBUG);
  assign ctl.inChkStop = (state == ST_CHK);

  // R7: debug state is only reached from a drained pipeline
  assert_drain_before_debug_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.inDebug) |-> ($past(state) == ST_DRAIN && $past(pipeEmpty)));

  // R6: no entry without an enabled pending cause
  assert_no_spurious_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !req.entryReq) |=> (state != ST_DRAIN));

  // R10: return command leaves debug mode on the next edge
  assert_return_exit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEBUG && dbgReturn) |=> (state == ST_RUN));

  // R11: check-stop is held until reset
  assert_chkstop_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHK) |=> (state == ST_CHK));
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dme_pkg::*;
#(
  parameter int NC = NUM_CAUSES,
  parameter int SW = STATUS_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NC-1:0] causeEvt,
  input  logic          msrRi,
  input  logic          msrEe,
  input  logic          msrMe,
  input  logic          bkptUnmask,
  input  logic          dbgEnable,
  input  logic          swFreeze,
  input  logic          enWr,
  input  logic [NC-1:0] enWdata,
  input  logic          causeRd,
  output logic [NC-1:0] causeRdata,
  input  logic          pipeEmpty,
  input  logic          dbgReturn,
  output logic          fetchFromPort,
  output logic          freeze,
  output logic [SW-1:0] statusCode,
  output logic          checkStop
);
  dmeReq_t req;
  dmeCtl_t ctl;

  dme_datapath #(.NC(NC), .SW(SW)) dp_i (
    .clk(clk), .rstN(rstN), .causeEvt(causeEvt), .msrRi(msrRi), .msrEe(msrEe),
    .msrMe(msrMe), .bkptUnmask(bkptUnmask), .dbgEnable(dbgEnable),
    .swFreeze(swFreeze), .enWr(enWr), .enWdata(enWdata), .causeRd(causeRd),
    .ctl(ctl), .req(req), .causeRdata(causeRdata), .fetchFromPort(fetchFromPort),
    .freeze(freeze), .statusCode(statusCode), .checkStop(checkStop)
  );

  dme_control ctl_i (
    .clk(clk), .rstN(rstN), .req(req), .pipeEmpty(pipeEmpty),
    .dbgReturn(dbgReturn), .ctl(ctl)
  );
endmodule

// File: tb/dbg_entry_ctrl_tb_top.sv
module dbg_entry_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] causeEvt = '0;
  logic msrRi = 0, msrEe = 0, msrMe = 0, bkptUnmask = 0, dbgEnable = 0, swFreeze = 0;
  logic enWr = 0, causeRd = 0, pipeEmpty = 0, dbgReturn = 0;
  logic [9:0] enWdata = '0;
  logic [9:0] causeRdata;
  logic fetchFromPort, freeze, checkStop;
  logic [1:0] statusCode;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R13";

  int mState = 0;          // 0 normal, 1 waiting, 2 debug, 3 check-stop
  logic [9:0] mCause = '0, mEn = '0;

  always #5 clk = ~clk;

  dbg_entry_ctrl dut_i (
    .clk(clk), .rstN(rstN), .causeEvt(causeEvt), .msrRi(msrRi), .msrEe(msrEe),
    .msrMe(msrMe), .bkptUnmask(bkptUnmask), .dbgEnable(dbgEnable),
    .swFreeze(swFreeze), .enWr(enWr), .enWdata(enWdata), .causeRd(causeRd),
    .causeRdata(causeRdata), .pipeEmpty(pipeEmpty), .dbgReturn(dbgReturn),
    .fetchFromPort(fetchFromPort), .freeze(freeze), .statusCode(statusCode),
    .checkStop(checkStop)
  );

  function automatic bit allowed(int i);
    case (i)
      0:       return msrMe == 1'b1;
      1, 2:    return msrEe == 1'b1;
      6, 7:    return msrRi || bkptUnmask;
      8:       return msrRi == 1'b1;
      default: return 1'b1;
    endcase
  endfunction

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic tick();
    logic [9:0] setv;
    bit pend, chk;
    @(posedge clk);
    if (!rstN) begin
      mState = 0; mCause = '0; mEn = '0;
    end else begin
      pend = dbgEnable && ((mCause & mEn) != 0);
      chk  = causeEvt[0] && !msrMe;
      setv = '0;
      for (int i = 0; i < 10; i++) if (causeEvt[i] && allowed(i)) setv[i] = 1'b1;
      case (mState)
        0: if (chk) mState = 3; else if (pend) mState = 1;
        1: if (chk) mState = 3; else if (pipeEmpty) mState = 2;
        2: if (dbgReturn) mState = 0;
        default: mState = 3;
      endcase
      mCause = (causeRd ? 10'h0 : mCause) | setv;
      if (enWr) mEn = enWdata;
    end
    @(negedge clk);
    cmp("causeRdata", 32'(causeRdata), 32'(mCause));
    cmp("fetchFromPort", 32'(fetchFromPort), 32'(mState == 2));
    cmp("freeze", 32'(freeze), 32'((mState == 2) || (!dbgEnable && swFreeze)));
    cmp("statusCode", 32'(statusCode), (mState == 2) ? 32'd3 : 32'd0);
    cmp("checkStop", 32'(checkStop), 32'(mState == 3));
  endtask

  task automatic pulse(int idx);
    causeEvt = 10'(1 << idx);
    tick();
    causeEvt = '0;
  endtask

  task automatic readCauses();
    causeRd = 1; tick(); causeRd = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  initial begin
    // R13: reset values
    tag = "R13";
    rstN = 0; tick(); tick(); rstN = 1; tick();

    // R4: external interrupt / decrementer gated by msrEe
    tag = "R4";
    msrEe = 0; pulse(1); pulse(2); tick();
    msrEe = 1; pulse(1); pulse(2); tick();

    // R1 and R9: sticky then clear on read
    tag = "R1"; tick(); tick();
    tag = "R9"; readCauses(); tick();
    // R9: set in the same cycle as a read wins
    pulse(3);
    causeEvt = 10'(1 << 4); causeRd = 1; tick(); causeEvt = '0; causeRd = 0; tick();
    readCauses();

    // R2: code and data breakpoints
    tag = "R2";
    msrRi = 0; bkptUnmask = 0; pulse(6); pulse(7); tick();
    bkptUnmask = 1; pulse(6); pulse(7); tick();
    bkptUnmask = 0; msrRi = 1; pulse(6); tick(); readCauses();

    // R3: peripheral breakpoint ignores bkptUnmask
    tag = "R3";
    msrRi = 0; bkptUnmask = 1; pulse(8); tick();
    msrRi = 1; pulse(8); tick(); readCauses(); bkptUnmask = 0;

    // R5: always-recognised causes with msrRi=0 and msrEe=0
    tag = "R5";
    msrRi = 0; msrEe = 0; pulse(9); pulse(3); pulse(4); pulse(5); tick(); readCauses();

    // R12: software freeze
    tag = "R12";
    swFreeze = 1; tick(); tick();
    dbgEnable = 1; tick(); dbgEnable = 0; swFreeze = 0; tick();

    // R6: pending cause without its enable bit, and with debug disabled
    tag = "R6";
    enWdata = 10'h200; enWr = 1; tick(); enWr = 0;
    dbgEnable = 1; pipeEmpty = 1; pulse(4); tick(); tick(); tick();
    dbgEnable = 0; pulse(9); tick(); tick(); tick();
    readCauses();

    // R7: wait for drain, then enter
    tag = "R7";
    dbgEnable = 1; pipeEmpty = 0; pulse(9);
    for (int k = 0; k < 5; k++) tick();
    pipeEmpty = 1; tick(); tick();

    // R8: outputs in debug mode, including with swFreeze and dbgEnable low
    tag = "R8";
    readCauses(); dbgEnable = 0; swFreeze = 0; tick(); tick();

    // R10: return command
    tag = "R10";
    dbgReturn = 1; tick(); dbgReturn = 0; tick(); tick();

    // R7: entry with pipeline already empty takes two edges after capture
    tag = "R7";
    dbgEnable = 1; pipeEmpty = 1; pulse(9); tick(); tick();
    readCauses(); dbgReturn = 1; tick(); dbgReturn = 0; tick();

    // R11: machine check
    tag = "R11";
    dbgEnable = 0; msrMe = 1; pulse(0); tick(); readCauses();
    msrMe = 0; pulse(0); tick(); tick();
    pulse(9); dbgReturn = 1; tick(); dbgReturn = 0; tick();
    tag = "R13";
    rstN = 0; tick(); rstN = 1; tick(); tick();

    summary();
  end
endmodule